// File: doc/BRIEF.md
# Gated DDR Capture Deserializer

This block takes a parallel data bus from an external device. The device sends a strobe that is already phase-aligned to the data. The block turns that stream into wide words for the core clock domain. A window input opens and closes the strobe. Only strobe cycles that fall inside the window deliver samples, so strobe toggling before or after a read burst never reaches the capture registers. The window is sampled on each falling strobe edge, and the sampled value governs the next strobe cycle. The rising edge of the qualified strobe captures one sample. In the double-rate variant, the falling edge captures a second sample. A counter packs the samples into a word. A parameter sets the number of samples per word: 2, 4 or 8 for double rate, and 1, 2 or 4 for single rate.

The strobe edge that completes a word also writes that word into an 8-entry read queue, with no extra pipeline stage. The queue crosses into the core clock domain through Gray-coded pointers. The core drains it with a read enable. The output valid follows that enable in the same cycle whenever a word is waiting. If a word completes while the queue is full, the word is dropped and a sticky overflow flag is raised. A synchronous active-low reset clears the pointers, the packing counter and the flag.

Top module: `gated_ddr_deser`

## Requirements
- R1: After `rst_n` has been held low across at least two core-clock edges and two strobe cycles, `rd_valid` and `overflow` are 0, even with `rd_en` high.
- R2: A strobe cycle contributes samples only if `win_en` was 1 at the falling strobe edge before it. Data presented during any other strobe cycle has no effect on the words produced.
- R3: In double-rate mode, sample lane i occupies bits [i*DW +: DW] of the word. Lane 2k holds the rising-edge sample and lane 2k+1 holds the falling-edge sample of the k-th qualified strobe cycle.
- R4: In single-rate mode, only the rising-edge sample of each qualified strobe cycle is kept. The k-th such sample goes to lane k.
- R5: A word is written on the strobe edge that supplies its last sample. The core side can read it no later than the third core-clock rising edge after that strobe edge.
- R6: `rd_valid` is 1 exactly when `rd_en` is 1 and the queue holds a word. `rd_word` shows that word in the same cycle, and the word is removed at the next core-clock rising edge. While `rd_en` is 0, nothing is removed.
- R7: Asserting `rd_en` on an empty queue gives `rd_valid` = 0 and has no effect on words written later.
- R8: The queue holds 8 words. A word completed while 8 words are waiting is dropped, and `overflow` rises within three core-clock edges. The 8 stored words are still read out in order.
- R9: `overflow` stays at 1 until reset and returns to 0 after reset.
- R10: Words leave the queue in the order they were completed.
- R11: Closing the window in the middle of a word keeps the partial word. Packing resumes at the next lane when the window reopens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Core clock for the read side |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| strobe | input | 1 | Source-synchronous strobe from the external device |
| win_en | input | 1 | Enable window, sampled on each falling strobe edge |
| pad_data | input | DW | Input data bus |
| rd_en | input | 1 | Core-side read enable |
| rd_word | output | SER*DW | Oldest waiting word |
| rd_valid | output | 1 | `rd_word` is valid and is consumed at the next core edge |
| overflow | output | 1 | Sticky flag: a word was dropped because the queue was full |

## Verification
A completed word reaches the core side after two synchronizer stages. The bench therefore waits five core cycles after the last strobe edge of a burst before it reads any word. `rd_valid` and `rd_word` depend combinationally on `rd_en`. The bench changes `rd_en` on a falling core edge and samples 1 ns later, so the same-cycle relation is checked before the next rising edge removes the word. The overflow flag crosses through two core flops. It is compared only after the same five-cycle wait, and it is checked again after the queue has been drained and after reset.

// File: rtl/gdd_pkg.sv
// Package: derived geometry shared by the capture, packing and queue stages.
package gdd_pkg;

    // Samples taken per qualified strobe cycle.
    function automatic int lanes_per_beat(input bit ddr);
        return ddr ? 2 : 1;
    endfunction

    // Qualified strobe cycles needed to fill one word.
    function automatic int beats_per_word(input int ser, input bit ddr);
        return ddr ? ser / 2 : ser;
    endfunction

    // Counter width that holds 0 .. n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gdd_gate.sv
// Strobe gate and rising-edge capture.
// Samples the enable window on each falling strobe edge. The sampled value
// qualifies the whole following strobe cycle. Since the gate only changes
// while the strobe is low, the cleaned strobe is free of glitches.
// The cleaned strobe's rising edge captures the rising-edge sample.
// Assumes: the strobe is already centred on the data eye.
module gdd_gate #(
    parameter int DW = 4
) (
    input  logic          strobe,
    input  logic          rst_n,
    input  logic          win_en,
    input  logic [DW-1:0] pad_data,
    output logic          gate_o,
    output logic [DW-1:0] rise_o
);
    logic gate_q;
    logic strobe_clean;

    // Latch the window at the falling edge so the next high phase is whole.
    always_ff @(negedge strobe) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= win_en;
    end

    assign strobe_clean = strobe & gate_q;

    // Capture the rising-edge sample on qualified edges only.
    always_ff @(posedge strobe_clean) begin
        rise_o <= pad_data;
    end

    assign gate_o = gate_q;

    AST_CLOSED_RISE_BLOCKED: assert property (@(posedge strobe) disable iff (!rst_n)
        !gate_q |=> $stable(rise_o)); // R2
endmodule

// File: rtl/gdd_packer.sv
// Beat packer.
// On every qualified falling strobe edge, one beat (one or two samples)
// goes into the next lane of the word being built. The word with the current
// beat merged in is offered combinationally, so the queue can take it on the
// same edge that completes it.
// Assumes: fire is stable around the falling strobe edge.
module gdd_packer #(
    parameter int DW  = 4,
    parameter int SER = 8,
    parameter bit DDR = 1'b1
) (
    input  logic                       strobe,
    input  logic                       rst_n,
    input  logic                       fire,
    input  logic [gdd_pkg::lanes_per_beat(DDR)*DW-1:0] beat_d,
    output logic                       wr_req,
    output logic [SER*DW-1:0]          word_o
);
    localparam int BW    = gdd_pkg::lanes_per_beat(DDR) * DW;
    localparam int BEATS = gdd_pkg::beats_per_word(SER, DDR);
    localparam int CW    = gdd_pkg::cnt_width(BEATS);
    localparam logic [CW-1:0] LAST = CW'(BEATS - 1);

    logic [CW-1:0]       cnt;
    logic [SER*DW-1:0]   acc;

    // Lane counter: advances on qualified beats and wraps after the last one.
    always_ff @(negedge strobe) begin
        if (!rst_n)          cnt <= '0;
        else if (fire)       cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Partial word storage: holds the earlier beats of the current word.
    always_ff @(negedge strobe) begin
        if (fire) acc[int'(cnt)*BW +: BW] <= beat_d;
    end

    // Complete word: the stored beats plus the beat arriving now.
    always_comb begin
        word_o = acc;
        word_o[int'(cnt)*BW +: BW] = beat_d;
    end

    assign wr_req = fire && (cnt == LAST);

    AST_CNT_RANGE: assert property (@(negedge strobe) disable iff (!rst_n)
        cnt <= LAST); // R11
    AST_CNT_HOLDS_CLOSED: assert property (@(negedge strobe) disable iff (!rst_n)
        !fire |=> $stable(cnt)); // R11
endmodule

// File: rtl/gdd_fifo.sv
// Dual-clock read queue.
// The write side runs on the falling strobe edge and the read side on
// core_clk. Pointers cross in Gray code through two flops. Reads are
// combinational, so valid and data follow rd_en in the same core cycle.
// A write while full is dropped and latches a sticky flag, which is then
// synchronized to the core side.
// Assumes: DEPTH is a power of two and at least 4.
module gdd_fifo #(
    parameter int WW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          strobe,
    input  logic          core_clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [WW-1:0] wr_word,
    input  logic          rd_en,
    output logic [WW-1:0] rd_word,
    output logic          rd_valid,
    output logic          overflow
);
    localparam int AW = $clog2(DEPTH);

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [WW-1:0] mem [DEPTH];
    logic [AW:0]   wbin, wgray, rq1, rq2;
    logic [AW:0]   rbin, rgray, wq1, wq2;
    logic          ovf_w, oq1, oq2;
    logic          full, empty, wr_ok;

    assign full  = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
    assign wr_ok = rst_n && wr_req && !full;

    // Write pointer, read-pointer synchronizer and overflow flag (strobe side).
    always_ff @(negedge strobe) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            rq1   <= '0;
            rq2   <= '0;
            ovf_w <= 1'b0;
        end else begin
            rq1 <= rgray;
            rq2 <= rq1;
            if (wr_ok) begin
                wbin  <= wbin + 1'b1;
                wgray <= to_gray(wbin + 1'b1);
            end
            if (wr_req && full) ovf_w <= 1'b1;
        end
    end

    // Storage write, on the same edge that completes the word.
    always_ff @(negedge strobe) begin
        if (wr_ok) mem[wbin[AW-1:0]] <= wr_word;
    end

    assign empty    = (rgray == wq2);
    assign rd_valid = rd_en && !empty;
    assign rd_word  = mem[rbin[AW-1:0]];

    // Read pointer, write-pointer and overflow synchronizers (core side).
    always_ff @(posedge core_clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            wq1   <= '0;
            wq2   <= '0;
            oq1   <= 1'b0;
            oq2   <= 1'b0;
        end else begin
            wq1 <= wgray;
            wq2 <= wq1;
            oq1 <= ovf_w;
            oq2 <= oq1;
            if (rd_valid) begin
                rbin  <= rbin + 1'b1;
                rgray <= to_gray(rbin + 1'b1);
            end
        end
    end

    assign overflow = oq2;

    AST_WPTR_GRAY_STEP: assert property (@(negedge strobe) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1); // R10
    AST_FULL_NO_WRITE: assert property (@(negedge strobe) disable iff (!rst_n)
        (wr_req && full) |=> $stable(wbin)); // R8
    AST_NO_POP_IDLE: assert property (@(posedge core_clk) disable iff (!rst_n)
        !rd_en |=> $stable(rbin)); // R6
    AST_OVF_STICKY: assert property (@(posedge core_clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
endmodule

// File: rtl/gated_ddr_deser.sv
// Gated source-synchronous capture deserializer (top).
// gate -> packer -> dual-clock queue. DDR_MODE selects two samples per
// strobe cycle (rising lane first) or one rising-edge sample.
// Assumes: SER is 2/4/8 with DDR_MODE=1, or 1/2/4 with DDR_MODE=0.
module gated_ddr_deser #(
    parameter int DW       = 4,
    parameter int SER      = 8,
    parameter bit DDR_MODE = 1'b1,
    parameter int DEPTH    = 8
) (
    input  logic              core_clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              win_en,
    input  logic [DW-1:0]     pad_data,
    input  logic              rd_en,
    output logic [SER*DW-1:0] rd_word,
    output logic              rd_valid,
    output logic              overflow
);
    localparam int BW = gdd_pkg::lanes_per_beat(DDR_MODE) * DW;
    localparam int WW = SER * DW;

    logic              gate;
    logic [DW-1:0]     rise_q;
    logic [BW-1:0]     beat;
    logic              wr_req;
    logic [WW-1:0]     word;

    gdd_gate #(.DW(DW)) u_gate (
        .strobe   (strobe),
        .rst_n    (rst_n),
        .win_en   (win_en),
        .pad_data (pad_data),
        .gate_o   (gate),
        .rise_o   (rise_q)
    );

    // Beat contents: falling sample above rising sample, or rising only.
    if (DDR_MODE) begin : g_ddr
        assign beat = {pad_data, rise_q};
    end else begin : g_sdr
        assign beat = rise_q;
    end

    gdd_packer #(.DW(DW), .SER(SER), .DDR(DDR_MODE)) u_pack (
        .strobe (strobe),
        .rst_n  (rst_n),
        .fire   (gate),
        .beat_d (beat),
        .wr_req (wr_req),
        .word_o (word)
    );

    gdd_fifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo (
        .strobe   (strobe),
        .core_clk (core_clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .wr_word  (word),
        .rd_en    (rd_en),
        .rd_word  (rd_word),
        .rd_valid (rd_valid),
        .overflow (overflow)
    );
endmodule

// File: tb/tb_gated_ddr_deser.sv
module tb_gated_ddr_deser;
    localparam int CLK_PERIOD = 10;
    localparam int SEED = 2024;

    logic        core_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic        win_en = 1'b0;
    logic [3:0]  pad_data = '0;
    logic        rd_en_d = 1'b0, rd_en_s = 1'b0;
    logic [31:0] word_d;
    logic [15:0] word_s;
    logic        val_d, val_s, ovf_d, ovf_s;

    int n_cmp = 0, n_mis = 0;

    always #(CLK_PERIOD/2) core_clk = ~core_clk;

    gated_ddr_deser #(.DW(4), .SER(8), .DDR_MODE(1'b1), .DEPTH(8)) dut (
        .core_clk(core_clk), .rst_n(rst_n), .strobe(strobe), .win_en(win_en),
        .pad_data(pad_data), .rd_en(rd_en_d), .rd_word(word_d),
        .rd_valid(val_d), .overflow(ovf_d));

    gated_ddr_deser #(.DW(4), .SER(4), .DDR_MODE(1'b0), .DEPTH(8)) dut_sdr (
        .core_clk(core_clk), .rst_n(rst_n), .strobe(strobe), .win_en(win_en),
        .pad_data(pad_data), .rd_en(rd_en_s), .rd_word(word_s),
        .rd_valid(val_s), .overflow(ovf_s));

    // Reference model state
    logic [31:0] q_d[$];
    logic [15:0] q_s[$];
    logic [31:0] acc_d;
    logic [15:0] acc_s;
    int          n_d, n_s, made;
    bit          gate_b, xovf_d, xovf_s;

    function automatic logic [31:0] put_lane32(input logic [31:0] w, input int i, input logic [3:0] v);
        logic [31:0] r = w;
        r[i*4 +: 4] = v;
        return r;
    endfunction

    function automatic logic [15:0] put_lane16(input logic [15:0] w, input int i, input logic [3:0] v);
        logic [15:0] r = w;
        r[i*4 +: 4] = v;
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model: one qualified strobe cycle (R3 lane order, R4 rising only, R8 capacity).
    task automatic model_open(input logic [3:0] r, input logic [3:0] f);
        acc_d = put_lane32(acc_d, n_d, r);
        acc_d = put_lane32(acc_d, n_d + 1, f);
        n_d += 2;
        if (n_d == 8) begin
            if (q_d.size() < 8) q_d.push_back(acc_d); else xovf_d = 1'b1;
            n_d = 0;
            made++;
        end
        acc_s = put_lane16(acc_s, n_s, r);
        n_s++;
        if (n_s == 4) begin
            if (q_s.size() < 8) q_s.push_back(acc_s); else xovf_s = 1'b1;
            n_s = 0;
        end
    endtask

    // One strobe cycle; win_next is seen at this cycle's falling edge.
    task automatic strobe_cycle(input logic [3:0] r, input logic [3:0] f, input bit win_next);
        pad_data = r;
        #2 strobe = 1'b1;
        #2 pad_data = f; win_en = win_next;
        #2 strobe = 1'b0;
        #2;
        if (gate_b) model_open(r, f);
        gate_b = win_next;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rd_en_d = 1'b0; rd_en_s = 1'b0; gate_b = 1'b0;
        repeat (3) strobe_cycle(4'h0, 4'h0, 1'b0);
        repeat (3) @(negedge core_clk);
        rst_n = 1'b1;
        q_d.delete(); q_s.delete();
        acc_d = '0; acc_s = '0; n_d = 0; n_s = 0; made = 0;
        xovf_d = 1'b0; xovf_s = 1'b0; gate_b = 1'b0;
    endtask

    // Read out both queues and compare against the model.
    task automatic drain(input string tag);
        int lim;
        repeat (5) @(negedge core_clk);
        #1;
        chk(val_d == 1'b0, "R6", "ddr valid with rd_en low", 32'(val_d), 0);
        chk(val_s == 1'b0, "R6", "sdr valid with rd_en low", 32'(val_s), 0);
        chk(ovf_d == xovf_d, "R8", "ddr overflow", 32'(ovf_d), 32'(xovf_d));
        chk(ovf_s == xovf_s, "R8", "sdr overflow", 32'(ovf_s), 32'(xovf_s));
        rd_en_d = 1'b1; rd_en_s = 1'b1;
        #1;
        chk(val_d == (q_d.size() > 0), "R6", "ddr same-cycle valid", 32'(val_d), 32'(q_d.size() > 0));
        lim = ((q_d.size() > q_s.size()) ? q_d.size() : q_s.size()) + 3;
        for (int i = 0; i < lim; i++) begin
            if (val_d) begin
                if (q_d.size() == 0) chk(1'b0, "R7", "ddr extra word", word_d, 0);
                else begin
                    chk(word_d == q_d[0], tag, "ddr word", word_d, q_d[0]);
                    void'(q_d.pop_front());
                end
            end
            if (val_s) begin
                if (q_s.size() == 0) chk(1'b0, "R7", "sdr extra word", 32'(word_s), 0);
                else begin
                    chk(word_s == q_s[0], tag, "sdr word", 32'(word_s), 32'(q_s[0]));
                    void'(q_s.pop_front());
                end
            end
            @(negedge core_clk);
            #1;
        end
        rd_en_d = 1'b0; rd_en_s = 1'b0;
        chk(q_d.size() == 0, "R5", "ddr words missing", 32'(q_d.size()), 0);
        chk(q_s.size() == 0, "R5", "sdr words missing", 32'(q_s.size()), 0);
    endtask

    // Random burst that ends with the window closed right after the last word.
    task automatic burst(input int target, input int closed_pct);
        made = 0;
        strobe_cycle(4'($urandom), 4'($urandom), 1'b1);
        while (made < target) begin
            bit last;
            last = gate_b && (n_d == 6) && (made + 1 == target);
            strobe_cycle(4'($urandom), 4'($urandom),
                         last ? 1'b0 : (($urandom % 100) >= closed_pct));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_mis++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(SEED);
        do_reset();

        // R1 / R7: reset state, reads on an empty queue.
        rd_en_d = 1'b1; rd_en_s = 1'b1;
        repeat (4) begin
            @(negedge core_clk); #1;
            chk(val_d == 1'b0 && val_s == 1'b0, "R1", "valid after reset", 32'({val_d, val_s}), 0);
            chk(ovf_d == 1'b0 && ovf_s == 1'b0, "R1", "overflow after reset", 32'({ovf_d, ovf_s}), 0);
        end
        rd_en_d = 1'b0; rd_en_s = 1'b0;

        // R3 / R4: directed lane order, expected 76543210 and 6420.
        strobe_cycle(4'h9, 4'h9, 1'b1);
        strobe_cycle(4'h0, 4'h1, 1'b1);
        strobe_cycle(4'h2, 4'h3, 1'b1);
        strobe_cycle(4'h4, 4'h5, 1'b1);
        strobe_cycle(4'h6, 4'h7, 1'b0);
        chk(q_d[0] == 32'h76543210 && q_s[0] == 16'h6420, "R3", "model lane order", q_d[0], 32'h76543210);
        drain("R3 R4 R7");

        // R11 / R2: window closes mid-word; garbage while closed is ignored.
        strobe_cycle(4'hA, 4'hA, 1'b1);
        strobe_cycle(4'h1, 4'h2, 1'b1);
        strobe_cycle(4'h3, 4'h4, 1'b0);
        strobe_cycle(4'hF, 4'hF, 1'b0);
        strobe_cycle(4'hE, 4'hE, 1'b1);
        strobe_cycle(4'h5, 4'h6, 1'b1);
        strobe_cycle(4'h7, 4'h8, 1'b0);
        strobe_cycle(4'hC, 4'hD, 1'b0);
        drain("R2 R11");

        // R8: nine words into an eight-entry queue.
        burst(9, 0);
        drain("R8");
        repeat (10) @(negedge core_clk);
        #1;
        chk(ovf_d == 1'b1 && ovf_s == 1'b1, "R9", "overflow sticky", 32'({ovf_d, ovf_s}), 32'h3);
        do_reset();
        repeat (2) @(negedge core_clk);
        #1;
        chk(ovf_d == 1'b0 && ovf_s == 1'b0, "R9", "overflow after reset", 32'({ovf_d, ovf_s}), 0);

        // R10 / R2: random rounds with random closed cycles.
        for (int k = 0; k < 20; k++) begin
            burst(1 + int'($urandom % 8), 30);
            drain("R10 R2");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule